// File: doc/BRIEF.md
# Nine-Bit Serial Receiver with Station Address Filter

This block receives asynchronous serial characters that carry nine data bits. It is meant for a multidrop link, where several stations share one line. The ninth bit tells an address character apart from a data character. A clock divider produces an oversampling tick at sixteen times the bit rate. Each character is recovered by majority voting near the centre of each bit. The first eight bits go to a data register and the ninth bit goes to its own flag.

A receive-complete flag drives the interrupt request. It stays set until software pulses a clear strobe. While filtering is switched off, every valid character raises the flag. While filtering is switched on, only an address character (ninth bit one) whose eight low bits equal the programmed station address raises it. The intended sequence is as follows. Software waits with filtering on. Once its own address arrives, it turns filtering off to collect the data block. When the block is complete, it turns filtering back on.

Top module: `uart9_addr_rx`

## Requirements
- R1: The line idles high. A character is one low start bit, then nine data bits with the least significant bit first, then one high stop bit. Each bit lasts 16*CLK_DIV clock cycles.
- R2: A start is confirmed by a majority of three oversampled values near the centre of the start bit. A low pulse shorter than a quarter bit is ignored and leaves every output unchanged.
- R3: Each data bit is the majority of three consecutive oversampled values near its centre, so a low or high glitch that lasts one clock inside a bit does not change the received value.
- R4: A character whose stop bit is sampled low is discarded: the flag, data and ninth-bit outputs keep their values.
- R5: With filter_en = 0, rx_en = 1 and the flag clear, every valid character sets irq_flag. It also loads bits 0..7 into rx_byte and bit 8 into rx_bit9.
- R6: With filter_en = 1, a character sets the flag and loads the outputs only when its ninth bit is 1 and bits 0..7 equal station_addr.
- R7: With filter_en = 1, a character whose ninth bit is 0 is discarded and leaves rx_byte and rx_bit9 unchanged.
- R8: A character that completes while rx_en = 0 is discarded.
- R9: The flag stays set until cleared. A character that completes while the flag is set is discarded, and rx_byte and rx_bit9 hold their values.
- R10: After reset, irq_flag, rx_byte and rx_bit9 are all zero.
- R11: A one-cycle pulse on flag_clr while the flag is set clears it on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rxd | input | 1 | Serial input line, idles high |
| rx_en | input | 1 | Reception enable |
| filter_en | input | 1 | Enables station address filtering |
| station_addr | input | 8 | Programmed station address |
| flag_clr | input | 1 | Strobe that clears irq_flag |
| rx_byte | output | 8 | Data bits 0..7 of the last accepted character |
| rx_bit9 | output | 1 | Ninth bit of the last accepted character |
| irq_flag | output | 1 | Receive-complete flag and interrupt request |

## Verification
The hardest case to reach is a character that is correctly framed but must be dropped, and the reason the port outputs show nothing has to be unambiguous. Three reasons can apply: an address mismatch, a data character while filtering is on, or an uncleared flag. The stimulus therefore sets the previous rx_byte value to something different from the dropped character before sending it, so that any wrong load is visible. It also mixes random filter settings, station-matching addresses, missed clears, bad stop bits and one-clock glitches inside the data bits.

// File: rtl/uart9_addr_rx.sv
module uart9_addr_rx #(
  parameter int CLK_DIV = 27,
  parameter int OVS     = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxd,
  input  logic       rx_en,
  input  logic       filter_en,
  input  logic [7:0] station_addr,
  input  logic       flag_clr,
  output logic [7:0] rx_byte,
  output logic       rx_bit9,
  output logic       irq_flag
);
  localparam int DW  = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam int SW  = $clog2(OVS);
  localparam int MID = OVS / 2;
  localparam int NB  = 9;

  typedef enum logic [1:0] {IDLE, START, DATA, STOP} st_t;

  st_t           st_q;
  logic [DW-1:0] div_q;
  logic [1:0]    sync_q;
  logic [SW-1:0] sub_q;
  logic [3:0]    bit_q;
  logic [1:0]    vote_q;
  logic [NB-1:0] shf_q;

  logic tick, line, decide, bit_end, maj, frame_done, hit, accept;

  assign tick    = (div_q == DW'(CLK_DIV - 1));
  assign line    = sync_q[1];
  assign decide  = tick && (sub_q == SW'(MID + 1));
  assign bit_end = tick && (sub_q == SW'(OVS - 1));
  assign maj     = (vote_q[0] & vote_q[1]) | (vote_q[0] & line) | (vote_q[1] & line);

  assign frame_done = (st_q == STOP) && decide && maj;
  assign hit        = !filter_en || (shf_q[8] && (shf_q[7:0] == station_addr));
  assign accept     = frame_done && rx_en && !irq_flag && hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      sync_q <= 2'b11;
    end else begin
      div_q  <= tick ? '0 : div_q + 1'b1;
      sync_q <= {sync_q[0], rxd};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= IDLE;
      sub_q  <= '0;
      bit_q  <= '0;
      vote_q <= 2'b11;
      shf_q  <= '0;
    end else if (tick) begin
      vote_q <= {vote_q[0], line};
      sub_q  <= bit_end ? '0 : sub_q + 1'b1;
      case (st_q)
        IDLE: begin
          sub_q <= SW'(1);
          if (!line) st_q <= START;
        end
        START: begin
          if (decide && maj) st_q <= IDLE;
          else if (bit_end) begin
            st_q  <= DATA;
            bit_q <= '0;
          end
        end
        DATA: begin
          if (decide) shf_q <= {maj, shf_q[NB-1:1]};
          if (bit_end) begin
            if (bit_q == 4'(NB - 1)) st_q <= STOP;
            else bit_q <= bit_q + 1'b1;
          end
        end
        STOP: begin
          if (decide) st_q <= IDLE;
        end
        default: st_q <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_byte  <= '0;
      rx_bit9  <= 1'b0;
      irq_flag <= 1'b0;
    end else if (accept) begin
      rx_byte  <= shf_q[7:0];
      rx_bit9  <= shf_q[8];
      irq_flag <= 1'b1;
    end else if (flag_clr) begin
      irq_flag <= 1'b0;
    end
  end

  // R6: a filtered acceptance always carries this station's address
  a_r6_addr_match: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq_flag) && $past(filter_en)) |-> (rx_bit9 && rx_byte == $past(station_addr)));

  // R8: no acceptance while reception is disabled
  a_r8_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> $past(rx_en));

  // R9: outputs frozen while the flag is pending
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    irq_flag |=> ($stable(rx_byte) && $stable(rx_bit9)));

  // R11: clear strobe drops a pending flag
  a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && irq_flag) |=> !irq_flag);

  // R1: data bit counter stays inside the nine-bit frame
  a_r1_bitcount: assert property (@(posedge clk) disable iff (!rst_n)
    bit_q <= 4'(NB - 1));

  // R4: a flag rise only follows the stop-bit decision
  a_r4_stop_sampled: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> (st_q == IDLE));
endmodule

// File: tb/test_uart9_addr_rx.sv
`timescale 1ns/1ps
module test_uart9_addr_rx;
  localparam int DIV = 2;
  localparam int BITCLK = 16 * DIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1;
  logic       rx_en = 1'b1;
  logic       filter_en = 1'b0;
  logic [7:0] station_addr = 8'h3C;
  logic       flag_clr = 1'b0;
  logic [7:0] rx_byte;
  logic       rx_bit9;
  logic       irq_flag;

  int vectors = 0;
  int fails = 0;
  logic       e_flag = 1'b0;
  logic [7:0] e_byte = 8'h00;
  logic       e_bit9 = 1'b0;

  always #5 clk = ~clk;

  uart9_addr_rx #(.CLK_DIV(DIV), .OVS(16)) i_uart9_addr_rx (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .rx_en(rx_en), .filter_en(filter_en),
    .station_addr(station_addr), .flag_clr(flag_clr),
    .rx_byte(rx_byte), .rx_bit9(rx_bit9), .irq_flag(irq_flag)
  );

  function automatic logic exp_accept(logic [8:0] d, logic stop_ok, logic en,
                                      logic filt, logic [7:0] addr, logic flag);
    return stop_ok && en && !flag && (!filt || (d[8] && d[7:0] == addr));
  endfunction

  task automatic check(string tag);
    @(negedge clk);
    vectors++;
    if ({irq_flag, rx_bit9, rx_byte} !== {e_flag, e_bit9, e_byte}) begin
      fails++;
      $display("FAIL %s: got flag=%0b bit9=%0b byte=%h, expected flag=%0b bit9=%0b byte=%h",
               tag, irq_flag, rx_bit9, rx_byte, e_flag, e_bit9, e_byte);
    end
  endtask

  task automatic send(logic [8:0] d, logic stop_ok, logic glitch);
    logic acc;
    acc = exp_accept(d, stop_ok, rx_en, filter_en, station_addr, e_flag);
    @(posedge clk); #1 rxd = 1'b0;
    repeat (BITCLK) @(posedge clk);
    for (int i = 0; i < 9; i++) begin
      #1 rxd = d[i];
      for (int c = 0; c < BITCLK; c++) begin
        @(posedge clk);
        if (glitch && c == 18) #1 rxd = ~d[i];
        if (glitch && c == 19) #1 rxd = d[i];
      end
    end
    #1 rxd = stop_ok;
    repeat (BITCLK) @(posedge clk);
    #1 rxd = 1'b1;
    repeat (BITCLK + 8) @(posedge clk);
    if (acc) begin
      e_flag = 1'b1;
      e_byte = d[7:0];
      e_bit9 = d[8];
    end
  endtask

  task automatic clear();
    @(posedge clk); #1 flag_clr = 1'b1;
    @(posedge clk); #1 flag_clr = 1'b0;
    e_flag = 1'b0;
  endtask

  initial begin
    #1_500_000;
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250));
    repeat (5) @(posedge clk);
    check("R10 reset");
    #1 rst_n = 1'b1;
    repeat (10) @(posedge clk);
    check("R10 after reset");

    send(9'h0A5, 1'b1, 1'b0); check("R5 plain frame");
    send(9'h12D, 1'b1, 1'b0); check("R9 flag pending drops frame");
    clear(); check("R11 clear strobe");
    send(9'h12D, 1'b1, 1'b0); check("R1 lsb-first ninth bit");
    clear();

    @(posedge clk); #1 rxd = 1'b0;
    repeat (7) @(posedge clk);
    #1 rxd = 1'b1;
    repeat (20 * BITCLK) @(posedge clk);
    check("R2 short low pulse ignored");
    send(9'h05A, 1'b1, 1'b0); check("R2 frame after glitch");
    clear();

    send(9'h0C3, 1'b1, 1'b1); check("R3 glitched bits");
    clear();

    filter_en = 1'b1;
    send(9'h03C, 1'b1, 1'b0); check("R7 data byte filtered");
    send(9'h13D, 1'b1, 1'b0); check("R6 wrong address");
    send(9'h13C, 1'b1, 1'b0); check("R6 own address");
    clear();
    filter_en = 1'b0;
    send(9'h077, 1'b1, 1'b0); check("R5 data after address");
    clear();

    send(9'h099, 1'b0, 1'b0); check("R4 bad stop bit");
    repeat (3 * BITCLK) @(posedge clk);
    rx_en = 1'b0;
    send(9'h044, 1'b1, 1'b0); check("R8 receive disabled");
    rx_en = 1'b1;

    for (int n = 0; n < 90; n++) begin
      logic [8:0] d;
      logic stop_ok, glitch;
      string tag;
      d = 9'($urandom);
      if ($urandom_range(0, 3) == 0) d = {1'b1, station_addr};
      filter_en = ($urandom_range(0, 1) == 1);
      rx_en     = ($urandom_range(0, 9) != 0);
      stop_ok   = ($urandom_range(0, 9) != 0);
      glitch    = ($urandom_range(0, 2) == 0);
      if ($urandom_range(0, 9) < 7) clear();
      if (!stop_ok) tag = "R4 random";
      else if (!rx_en) tag = "R8 random";
      else if (e_flag) tag = "R9 random";
      else if (!filter_en) tag = glitch ? "R3 random" : "R5 random";
      else if (!d[8]) tag = "R7 random";
      else tag = "R6 random";
      send(d, stop_ok, glitch);
      check(tag);
      if (!stop_ok) repeat (3 * BITCLK) @(posedge clk);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule